// File: doc/BRIEF.md
# Two-Phase Associative Cache Slave

This block is a small fully associative cache that answers a processor bus run on a two-phase cycle. Each entry has a tag store holding one line address with valid, shared and master flags, and a data store holding one word. Phases A and B alternate on successive rising clock edges. Phase A always comes first after reset.

At the edge that closes phase A, the block latches the bus command and the memory-side shared-cycle flag. If that flag is clear, it also compares the address on the processor input bus against every valid tag. It keeps a hit flag and the lowest matching entry index. During phase B it drives the matched word for a fetch that hit. It raises reject when the lookup missed or the shared-cycle flag was set. At the edge that closes phase B, a store that hit while the flag was clear writes the bus value into the matched entry.

Reset clears the shared-cycle flag and the data store, and invalidates every entry. Entries 1, 2 and 3 are then loaded as valid with line addresses 1, 2 and 3, and with both flags cleared. Refill, coherence and replacement belong to other blocks.

Top module: `cam_slave_cache`

## Requirements
- R1: After a synchronous active-low reset, entries 1, 2 and 3 are the only valid entries and hold line addresses 1, 2 and 3. Every data word reads as zero, and every shared and master flag is zero.
- R2: `phase_b` is low in the first cycle after reset and then toggles on every rising edge.
- R3: In phase B after a fetch (command 01) that hit, `bus_oe` is high and `bus_dout` carries the matched entry's word. `reject` is low unless R7 applies.
- R4: A lookup that finds no valid tag equal to the address raises `reject` in phase B. An invalid entry never matches, even when its stored address is equal. Whenever `bus_oe` is low, `bus_dout` is zero.
- R5: A store (command 10) that hit with the shared-cycle flag clear writes `bus_din`, as sampled at the edge ending phase B, into the matched entry.
- R6: A store that missed leaves every data word unchanged.
- R7: If `shared_busy` is high at the edge ending phase A, the next phase B raises `reject`. The previous hit flag and index stay unchanged, so a fetch drives the previously matched word. A store in that cycle writes nothing.
- R8: Commands 00 and 11 are idle. They never drive the bus, and `reject` in phase B still reflects the lookup result.
- R9: During phase A, `bus_oe`, `reject` and `bus_dout` are all zero.
- R10: `shared_busy` is sampled only at the edge ending phase A. Its value during phase B affects neither reject nor the write.
- R11: The tag compare uses the full word width. An address that differs from a tag only in its top bit misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; phases alternate on rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cmd | input | 2 | 00 idle, 01 fetch, 10 store, 11 idle |
| bus_din | input | WORD_W | Address in phase A, store data in phase B |
| shared_busy | input | 1 | Memory side is running a shared cycle |
| bus_dout | output | WORD_W | Fetch data, zero when not driven |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| reject | output | 1 | Miss or shared cycle, phase B only |
| phase_b | output | 1 | High during phase B |

## Verification
The assertions take for granted that `shared_busy` settles before each rising edge and that reset is held for at least one edge. The phase, reject-on-busy and match-hold properties compare `$past` values of that input with the latched lookup state. The stimulus changes inputs only on falling edges. It toggles `shared_busy` in both phases, so the checks confirm that only the phase A value counts. Addresses are drawn both from the preloaded lines and from nearby unloaded ones, so hits, misses and held results all occur.

// File: rtl/cam_slave_pkg.sv
// Shared command encoding for the two-phase cache slave.
package cam_slave_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_FETCH = 2'b01,
        CMD_STORE = 2'b10,
        CMD_NOP   = 2'b11
    } bus_cmd_e;
endpackage

// File: rtl/cam_phase_gen.sv
// Phase generator: produces alternating phase A / phase B enables.
// Assumes a synchronous active-low reset; phase A follows reset.
module cam_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic phase_b
);
    // Toggle phase on every edge, starting in phase A.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_b <= 1'b0;
        else        phase_b <= ~phase_b;
    end
endmodule

// File: rtl/cam_tag_array.sv
// Tag store with parallel compare and lowest-index priority select.
// Assumes tags change only at reset (no refill path); entries 1..PRELOAD_COUNT
// are preloaded with their own index as line address.
module cam_tag_array #(
    parameter int NUM_ENTRIES   = 8,
    parameter int WORD_W        = 32,
    parameter int IDX_W         = 3,
    parameter int PRELOAD_COUNT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WORD_W-1:0]      lookup_addr,
    output logic                   match_hit,
    output logic [IDX_W-1:0]       match_idx,
    output logic [NUM_ENTRIES-1:0] tag_shared,
    output logic [NUM_ENTRIES-1:0] tag_master
);
    logic [WORD_W-1:0]      va_r [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] valid_r;
    logic [NUM_ENTRIES-1:0] hit_vec;

    // Reset preload of tags and per-entry flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                valid_r[i]    <= (i >= 1) && (i <= PRELOAD_COUNT);
                va_r[i]       <= ((i >= 1) && (i <= PRELOAD_COUNT)) ? WORD_W'(i) : '0;
                tag_shared[i] <= 1'b0;
                tag_master[i] <= 1'b0;
            end
        end
    end

    // One comparator per entry; invalid entries never match.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_r[g] && (va_r[g] == lookup_addr);
    end

    // Priority select: lowest matching index wins.
    always_comb begin
        match_hit = 1'b0;
        match_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                match_hit = 1'b1;
                match_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cam_word_ram.sv
// One word per entry data store; asynchronous read, synchronous write.
// Assumes write index is always in range; contents clear on reset.
module cam_word_ram #(
    parameter int NUM_ENTRIES = 8,
    parameter int WORD_W      = 32,
    parameter int IDX_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [NUM_ENTRIES];

    // Clear on reset, write one word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Combinational read of the selected entry.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/cam_slave_cache.sv
// Top: two-phase associative cache slave. Phase A latches command,
// shared-cycle flag and (when the flag is clear) the lookup result;
// phase B drives fetch data and reject, and its closing edge commits stores.
// Assumes inputs are stable around each rising edge.
module cam_slave_cache #(
    parameter int NUM_ENTRIES   = 8,
    parameter int WORD_W        = 32,
    parameter int PRELOAD_COUNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_cmd,
    input  logic [WORD_W-1:0] bus_din,
    input  logic              shared_busy,
    output logic [WORD_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              reject,
    output logic              phase_b
);
    import cam_slave_pkg::*;

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    bus_cmd_e               cmd_q;
    logic                   busy_q;
    logic                   hit_q;
    logic [IDX_W-1:0]       hit_idx_q;
    logic                   match_hit;
    logic [IDX_W-1:0]       match_idx;
    logic [NUM_ENTRIES-1:0] tag_shared;
    logic [NUM_ENTRIES-1:0] tag_master;
    logic                   wr_en;
    logic [WORD_W-1:0]      rd_data;

    cam_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_b (phase_b)
    );

    cam_tag_array #(
        .NUM_ENTRIES   (NUM_ENTRIES),
        .WORD_W        (WORD_W),
        .IDX_W         (IDX_W),
        .PRELOAD_COUNT (PRELOAD_COUNT)
    ) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .lookup_addr (bus_din),
        .match_hit   (match_hit),
        .match_idx   (match_idx),
        .tag_shared  (tag_shared),
        .tag_master  (tag_master)
    );

    cam_word_ram #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .WORD_W      (WORD_W),
        .IDX_W       (IDX_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (hit_idx_q),
        .wr_data (bus_din),
        .rd_idx  (hit_idx_q),
        .rd_data (rd_data)
    );

    // Phase A edge: capture command, shared flag and, if allowed, the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_IDLE;
            busy_q    <= 1'b0;
            hit_q     <= 1'b0;
            hit_idx_q <= '0;
        end else if (!phase_b) begin
            cmd_q  <= bus_cmd_e'(bus_cmd);
            busy_q <= shared_busy;
            if (!shared_busy) begin
                hit_q     <= match_hit;
                hit_idx_q <= match_idx;
            end
        end
    end

    // Store commit at the phase B edge.
    assign wr_en = phase_b && (cmd_q == CMD_STORE) && !busy_q && hit_q;

    // Phase B outputs: fetch data drive and reject.
    assign bus_oe   = phase_b && (cmd_q == CMD_FETCH) && hit_q;
    assign bus_dout = bus_oe ? rd_data : '0;
    assign reject   = phase_b && (!hit_q || busy_q);
endmodule

// File: rtl/cam_slave_cache_chk.sv
// Property checker for cam_slave_cache, attached by bind below.
module cam_slave_cache_chk #(
    parameter int NUM_ENTRIES = 8,
    parameter int WORD_W      = 32,
    parameter int IDX_W       = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   phase_b,
    input logic                   shared_busy,
    input logic                   bus_oe,
    input logic [WORD_W-1:0]      bus_dout,
    input logic                   reject,
    input logic                   hit_q,
    input logic [IDX_W-1:0]       hit_idx_q,
    input logic [NUM_ENTRIES-1:0] tag_shared,
    input logic [NUM_ENTRIES-1:0] tag_master
);
    AST_PHASE_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_b |-> (!bus_oe && !reject && bus_dout == '0)); // R9
    AST_PHASE_B_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        phase_b |=> !phase_b); // R2
    AST_PHASE_A_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_b |=> phase_b); // R2
    AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_b && $past(shared_busy)) |-> reject); // R7
    AST_BUSY_HOLDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_b && shared_busy) |=> ($stable(hit_q) && $stable(hit_idx_q))); // R7
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_dout == '0)); // R4
    AST_DRIVE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> hit_q); // R3
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_shared == '0) && (tag_master == '0)); // R1
endmodule

bind cam_slave_cache cam_slave_cache_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .WORD_W      (WORD_W),
    .IDX_W       (IDX_W)
) u_chk (.*);

// File: tb/tb_cam_slave_cache.sv
// Bench: behavioural reference model compared with the outputs every clock.
module tb_cam_slave_cache;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int W  = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   bus_cmd;
    logic [W-1:0] bus_din;
    logic         shared_busy;
    logic [W-1:0] bus_dout;
    logic         bus_oe;
    logic         reject;
    logic         phase_b;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    bit           m_ph;
    int           m_cmd;
    bit           m_busy;
    bit           m_hit;
    int           m_idx;
    int           m_line [int];
    logic [W-1:0] m_ram [NE];

    cam_slave_cache #(.NUM_ENTRIES(NE), .WORD_W(W), .PRELOAD_COUNT(3)) dut (
        .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_din(bus_din),
        .shared_busy(shared_busy), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .reject(reject), .phase_b(phase_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; fails++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        finish_run();
    end

    // Advance the model by one rising edge using the driven inputs.
    task automatic model_edge();
        if (!rst_n) begin
            m_ph = 0; m_cmd = 0; m_busy = 0; m_hit = 0; m_idx = 0;
            m_line.delete();
            for (int k = 1; k <= 3; k++) m_line[k] = k;  // line address k lives in entry k
            for (int k = 0; k < NE; k++) m_ram[k] = '0;
        end else if (!m_ph) begin
            m_cmd  = int'(bus_cmd);
            m_busy = shared_busy;
            if (!shared_busy) begin
                m_hit = 0;
                if (bus_din < W'(64) && m_line.exists(int'(bus_din))) begin
                    m_hit = 1; m_idx = m_line[int'(bus_din)];
                end
            end
            m_ph = 1;
        end else begin
            if (m_cmd == 2 && !m_busy && m_hit) m_ram[m_idx] = bus_din;
            m_ph = 0;
        end
    endtask

    task automatic compare(string tag);
        logic         e_oe, e_rej;
        logic [W-1:0] e_dout;
        e_oe   = m_ph && (m_cmd == 1) && m_hit;
        e_dout = e_oe ? m_ram[m_idx] : '0;
        e_rej  = m_ph && (!m_hit || m_busy);
        checks++;
        if (phase_b !== m_ph) begin
            fails++;
            $display("FAIL R2 phase: actual=%0b expected=%0b", phase_b, m_ph);
        end
        checks++;
        if (bus_oe !== e_oe || bus_dout !== e_dout || reject !== e_rej) begin
            fails++;
            $display("FAIL %s: actual oe=%0b dout=%h rej=%0b expected oe=%0b dout=%h rej=%0b",
                     tag, bus_oe, bus_dout, reject, e_oe, e_dout, e_rej);
        end
    endtask

    task automatic tick(input logic [1:0] c, input logic [W-1:0] d, input logic b, input string tag);
        @(negedge clk);
        bus_cmd = c; bus_din = d; shared_busy = b;
        @(posedge clk);
        #1;
        model_edge();
        #(CLK_PERIOD/4);
        compare(tag);
    endtask

    // One full bus cycle: phase A (address) then phase B (data).
    task automatic access(input logic [1:0] c, input logic [W-1:0] addr, input logic [W-1:0] wdata,
                          input logic busy_a, input logic busy_b, input string tag);
        tick(c, addr, busy_a, tag);
        tick(c, wdata, busy_b, "R9");
    endtask

    initial begin
        rst_n = 1'b0; bus_cmd = 2'b00; bus_din = '0; shared_busy = 1'b0;
        tick(2'b00, '0, 1'b0, "R1");
        tick(2'b00, '0, 1'b0, "R1");
        rst_n = 1'b1;
        // R1: preloaded lines hit with zero data; others miss.
        access(2'b01, 32'd1, '0, 0, 0, "R1");
        access(2'b01, 32'd3, '0, 0, 0, "R1");
        access(2'b01, 32'd4, '0, 0, 0, "R1");
        // R4: entry 0 is invalid, so address 0 misses.
        access(2'b01, 32'd0, '0, 0, 0, "R4");
        // R5: stores that hit, then read back (R3).
        access(2'b10, 32'd2, 32'hA5A5_5A5A, 0, 0, "R5");
        access(2'b10, 32'd1, 32'h1111_0001, 0, 0, "R5");
        access(2'b10, 32'd3, 32'h3333_0003, 0, 0, "R5");
        access(2'b01, 32'd2, '0, 0, 0, "R3");
        access(2'b01, 32'd1, '0, 0, 0, "R3");
        // R6: store miss, then existing words unchanged.
        access(2'b10, 32'd5, 32'hDEAD_BEEF, 0, 0, "R6");
        access(2'b01, 32'd3, '0, 0, 0, "R6");
        // R11: top-bit difference misses.
        access(2'b01, 32'h8000_0002, '0, 0, 0, "R11");
        // R7: busy holds previous hit; fetch drives the old word, reject high.
        access(2'b01, 32'd2, '0, 0, 0, "R3");
        access(2'b01, 32'd7, '0, 1, 1, "R7");
        // R7: store under busy writes nothing.
        access(2'b10, 32'd3, 32'hBAD0_BAD0, 1, 0, "R7");
        access(2'b01, 32'd3, '0, 0, 0, "R7");
        // R7: busy after a miss keeps the miss.
        access(2'b01, 32'd9, '0, 0, 0, "R4");
        access(2'b01, 32'd1, '0, 1, 0, "R7");
        // R10: busy only in phase B is ignored.
        access(2'b10, 32'd1, 32'h0F0F_F0F0, 0, 1, "R10");
        access(2'b01, 32'd1, '0, 0, 1, "R10");
        // R8: idle codes 00 and 11.
        access(2'b00, 32'd1, '0, 0, 0, "R8");
        access(2'b11, 32'd2, '0, 0, 0, "R8");
        access(2'b00, 32'd6, '0, 0, 0, "R8");
        // Mixed traffic against the model.
        for (int n = 0; n < 300; n++) begin
            logic [1:0]   c;
            logic [W-1:0] a, d;
            logic         ba, bb;
            c  = 2'($urandom_range(0, 3));
            a  = W'($urandom_range(0, 9));
            d  = W'($urandom);
            ba = ($urandom_range(0, 3) == 0);
            bb = ($urandom_range(0, 1) == 0);
            access(c, a, d, ba, bb, "R3");
        end
        finish_run();
    end
endmodule